// File: doc/BRIEF.md
# Color Field Sequencer with Dark Insertion

This block builds the illumination schedule for one frame of a color-sequential light modulator. A register table holds a list of segments. Each segment is red, green, blue or dark, and each has its own length in clock ticks. A frame-start pulse makes the sequencer walk through the valid part of the table in order. For every segment it drives the matching LED enable. For every lit segment it also raises a one-cycle request that asks the modulator to load that segment's bit planes.

Software writes the table while the sequencer is idle. It can split each color into many short interleaved segments of unequal length, for example blue, green, red, green, red, blue, green, red, green, red. It can also end the frame with a blank stretch, either with explicit dark entries or by making the table shorter than the frame period. Once the last entry expires, every LED stays off until the next frame start. If a frame start arrives while a schedule is still running, the current frame is cut short, the schedule restarts from entry 0, and a sticky flag records the event.

Top module: `fseq_top`

## Requirements
- R1: While reset is asserted and after it is released, `led_en`, `load_req`, `seq_active` and `overrun` are all 0 until the first frame start is sampled.
- R2: A write with `cfg_we` stores into entry `cfg_addr` a color code (00 red, 01 green, 10 blue, 11 dark) and a tick count. A write with `cfg_cnt_we` sets the number of valid entries. In `led_en`, bit 0 is red, bit 1 is green and bit 2 is blue.
- R3: When a frame start is sampled with a non-zero entry count, entry 0 appears at the outputs from the next cycle on. The entries then follow in index order, and each lasts its tick count in cycles. A tick count of 0 lasts one cycle.
- R4: During a colored segment exactly one LED enable is high, and it is the one for that segment's color. During a dark segment none is high. The enables change only where one segment ends and the next begins.
- R5: `load_req` is high for exactly the first cycle of each non-dark segment. In that cycle `load_color` carries the segment's color code, and `load_index` carries the number of earlier segments of the same color in the current frame, starting at 0.
- R6: After the last valid entry expires, `seq_active` and all LED enables are 0 and `load_req` stays low until the next frame start.
- R7: A frame start sampled while `seq_active` is high abandons the current segment and restarts at entry 0, with the per-color indices reset to 0. It also sets `overrun`, which then stays at 1 until reset.
- R8: With an entry count of 0, a frame start leaves the sequencer idle. A count above the table depth of 24 is treated as 24.
- R9: `seq_active` is high in exactly those cycles in which a table entry, colored or dark, is being shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one table entry |
| cfg_addr | input | 5 | Index of the entry being written |
| cfg_color | input | 2 | Color code of the entry being written |
| cfg_ticks | input | 16 | Duration of the entry being written, in clock ticks |
| cfg_cnt_we | input | 1 | Write strobe for the entry count |
| cfg_cnt | input | 5 | Number of valid entries |
| frame_start | input | 1 | One-cycle pulse that starts a frame |
| led_en | output | 3 | One-hot LED enables (bit 0 red, bit 1 green, bit 2 blue) |
| load_req | output | 1 | Bit-plane load request, one cycle per lit segment |
| load_color | output | 2 | Color code of the requested load |
| load_index | output | 5 | Occurrence number of that color within the frame |
| seq_active | output | 1 | A table entry is being shown |
| overrun | output | 1 | Sticky flag: a frame started before the previous one finished |

## Verification
A wrong entry pointer appears at `led_en` in the very next segment as the wrong color or the wrong order, and a wrong remaining-tick count shifts every later boundary by the error. A faulty per-color occurrence counter shows only in `load_index`, in the first cycle of the next segment of that color. The bench therefore compares the packed outputs against an independent model in every cycle of every frame. A stale run flag appears as enables staying lit, or `seq_active` staying high, in the cycle after the last entry. An abort that fails to reset the occurrence counts appears as a non-zero `load_index` on the first segment after the restart.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  localparam int NCOL = 3;

  typedef enum logic [1:0] {
    COL_R    = 2'b00,
    COL_G    = 2'b01,
    COL_B    = 2'b10,
    COL_DARK = 2'b11
  } col_e;

  function automatic logic [NCOL-1:0] col_onehot(input col_e c);
    logic [NCOL-1:0] v;
    case (c)
      COL_R:   v = 3'b001;
      COL_G:   v = 3'b010;
      COL_B:   v = 3'b100;
      default: v = 3'b000;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/fseq_table.sv
module fseq_table
  import fseq_pkg::*;
#(
  parameter int DEPTH  = 24,
  parameter int TICK_W = 16,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_color,
  input  logic [TICK_W-1:0] wr_ticks,
  input  logic              cnt_en,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic [ADDR_W-1:0] rd_idx,
  output col_e              rd_color,
  output logic [TICK_W-1:0] rd_ticks,
  output logic [CNT_W-1:0]  num_valid
);

  logic [1:0]        col_q [DEPTH];
  logic [TICK_W-1:0] tck_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;

  // one register pair per entry, each with its own write enable
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        col_q[i] <= 2'b11;
        tck_q[i] <= '0;
      end else if (hit) begin
        col_q[i] <= wr_color;
        tck_q[i] <= wr_ticks;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_val;
    end
  end

  // counts beyond the table depth saturate
  always_comb begin
    if (int'(cnt_q) > DEPTH) num_valid = CNT_W'(DEPTH);
    else                     num_valid = cnt_q;
  end

  always_comb begin
    rd_color = COL_DARK;
    rd_ticks = '0;
    if (int'(rd_idx) < DEPTH) begin
      rd_color = col_e'(col_q[rd_idx]);
      rd_ticks = tck_q[rd_idx];
    end
  end

endmodule

// File: rtl/fseq_occ.sv
module fseq_occ
  import fseq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bump,
  input  col_e             col,
  output logic [CNT_W-1:0] occ
);

  logic [CNT_W-1:0] cnt_q [NCOL];
  logic [CNT_W-1:0] cnt_d [NCOL];
  logic [NCOL-1:0]  cnt_en;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic mine;
    assign mine = bump && (col == col_e'(c));

    always_comb begin
      cnt_en[c] = clr || mine;
      cnt_d[c]  = (clr ? '0 : cnt_q[c]) + (mine ? CNT_W'(1) : CNT_W'(0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[c] <= '0;
      end else if (cnt_en[c]) begin
        cnt_q[c] <= cnt_d[c];
      end
    end
  end

  // occurrence number the segment now being loaded will carry
  always_comb begin
    occ = '0;
    for (int c = 0; c < NCOL; c++) begin
      if (col == col_e'(c)) occ = cnt_q[c];
    end
    if (clr) occ = '0;
  end

endmodule

// File: rtl/fseq_engine.sv
module fseq_engine
  import fseq_pkg::*;
#(
  parameter int TICK_W = 16,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [CNT_W-1:0]  num_valid,
  input  col_e              ent_color,
  input  logic [TICK_W-1:0] ent_ticks,
  input  logic [CNT_W-1:0]  ent_occ,
  output logic [ADDR_W-1:0] rd_idx,
  output logic              occ_clr,
  output logic              occ_bump,
  output logic [NCOL-1:0]   led_en,
  output logic              load_req,
  output logic [1:0]        load_color,
  output logic [CNT_W-1:0]  load_index,
  output logic              seq_active,
  output logic              overrun
);

  logic              act_q,  act_d;
  logic [ADDR_W-1:0] idx_q,  idx_d;
  logic [TICK_W-1:0] rem_q,  rem_d;
  logic [NCOL-1:0]   led_q,  led_d;
  logic              lreq_q, lreq_d;
  logic [1:0]        lcol_q, lcol_d;
  logic [CNT_W-1:0]  lidx_q, lidx_d;
  logic              ovr_q,  ovr_d;

  logic go, kill, expire, last, step, done, load;

  always_comb begin
    go     = frame_start && (num_valid != '0);
    kill   = frame_start && (num_valid == '0);
    expire = act_q && (rem_q == '0);
    last   = (int'(idx_q) + 1) >= int'(num_valid);
    step   = expire && !last && !frame_start;
    done   = (expire && last && !frame_start) || kill;
    load   = go || step;
    rd_idx = go ? '0 : idx_q + ADDR_W'(1);

    occ_clr  = go;
    occ_bump = load && (ent_color != COL_DARK);

    act_d  = act_q;
    idx_d  = idx_q;
    rem_d  = rem_q;
    led_d  = led_q;
    lreq_d = 1'b0;
    lcol_d = lcol_q;
    lidx_d = lidx_q;
    ovr_d  = ovr_q || (frame_start && act_q);

    if (load) begin
      act_d  = 1'b1;
      idx_d  = rd_idx;
      rem_d  = (ent_ticks == '0) ? '0 : ent_ticks - TICK_W'(1);
      led_d  = col_onehot(ent_color);
      lreq_d = (ent_color != COL_DARK);
      lcol_d = ent_color;
      lidx_d = ent_occ;
    end else if (done) begin
      act_d = 1'b0;
      led_d = '0;
    end else if (act_q) begin
      rem_d = rem_q - TICK_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      idx_q  <= '0;
      rem_q  <= '0;
      led_q  <= '0;
      lreq_q <= 1'b0;
      lcol_q <= 2'b00;
      lidx_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      idx_q  <= idx_d;
      rem_q  <= rem_d;
      led_q  <= led_d;
      lreq_q <= lreq_d;
      lcol_q <= lcol_d;
      lidx_q <= lidx_d;
      ovr_q  <= ovr_d;
    end
  end

  assign led_en     = led_q;
  assign load_req   = lreq_q;
  assign load_color = lcol_q;
  assign load_index = lidx_q;
  assign seq_active = act_q;
  assign overrun    = ovr_q;

endmodule

// File: rtl/fseq_top.sv
module fseq_top
  import fseq_pkg::*;
#(
  parameter int DEPTH  = 24,
  parameter int TICK_W = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [1:0]        cfg_color,
  input  logic [TICK_W-1:0] cfg_ticks,
  input  logic              cfg_cnt_we,
  input  logic [CNT_W-1:0]  cfg_cnt,
  input  logic              frame_start,
  output logic [2:0]        led_en,
  output logic              load_req,
  output logic [1:0]        load_color,
  output logic [CNT_W-1:0]  load_index,
  output logic              seq_active,
  output logic              overrun
);

  logic [ADDR_W-1:0] rd_idx;
  col_e              ent_color;
  logic [TICK_W-1:0] ent_ticks;
  logic [CNT_W-1:0]  num_valid;
  logic [CNT_W-1:0]  ent_occ;
  logic              occ_clr;
  logic              occ_bump;

  fseq_table #(
    .DEPTH (DEPTH),
    .TICK_W(TICK_W),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_addr  (cfg_addr),
    .wr_color (cfg_color),
    .wr_ticks (cfg_ticks),
    .cnt_en   (cfg_cnt_we),
    .cnt_val  (cfg_cnt),
    .rd_idx   (rd_idx),
    .rd_color (ent_color),
    .rd_ticks (ent_ticks),
    .num_valid(num_valid)
  );

  fseq_occ #(
    .CNT_W(CNT_W)
  ) u_occ (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (occ_clr),
    .bump (occ_bump),
    .col  (ent_color),
    .occ  (ent_occ)
  );

  fseq_engine #(
    .TICK_W(TICK_W),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .num_valid  (num_valid),
    .ent_color  (ent_color),
    .ent_ticks  (ent_ticks),
    .ent_occ    (ent_occ),
    .rd_idx     (rd_idx),
    .occ_clr    (occ_clr),
    .occ_bump   (occ_bump),
    .led_en     (led_en),
    .load_req   (load_req),
    .load_color (load_color),
    .load_index (load_index),
    .seq_active (seq_active),
    .overrun    (overrun)
  );

endmodule

// File: rtl/fseq_checker.sv
module fseq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic [2:0] led_en,
  input logic       load_req,
  input logic [1:0] load_color,
  input logic       seq_active,
  input logic       overrun
);

  AST_LED_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(led_en)); // R4

  AST_LED_ONLY_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ((led_en != 3'b000) && !$stable(led_en)) |-> load_req); // R4

  AST_LOAD_MATCHES_LED: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |-> ((load_color != 2'b11) && (led_en == (3'b001 << load_color)))); // R5

  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_active |-> ((led_en == 3'b000) && !load_req)); // R6

  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && seq_active) |=> overrun); // R7

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R7

endmodule

bind fseq_top fseq_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_start(frame_start),
  .led_en     (led_en),
  .load_req   (load_req),
  .load_color (load_color),
  .seq_active (seq_active),
  .overrun    (overrun)
);

// File: tb/fseq_top_bench.sv
module fseq_top_bench;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [1:0]  cfg_color;
  logic [15:0] cfg_ticks;
  logic        cfg_cnt_we;
  logic [4:0]  cfg_cnt;
  logic        frame_start;
  logic [2:0]  led_en;
  logic        load_req;
  logic [1:0]  load_color;
  logic [4:0]  load_index;
  logic        seq_active;
  logic        overrun;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int ecol [24];
  int etk  [24];

  fseq_top u_fseq_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_color  (cfg_color),
    .cfg_ticks  (cfg_ticks),
    .cfg_cnt_we (cfg_cnt_we),
    .cfg_cnt    (cfg_cnt),
    .frame_start(frame_start),
    .led_en     (led_en),
    .load_req   (load_req),
    .load_color (load_color),
    .load_index (load_index),
    .seq_active (seq_active),
    .overrun    (overrun)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // packed view: {active, led[2:0], load_req, color, index}
  function automatic logic [31:0] obs();
    return {20'd0, seq_active, led_en, load_req,
            load_req ? load_color : 2'b00,
            load_req ? load_index : 5'd0};
  endfunction

  task automatic wr_entry(input int a, input int c, input int t);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_color = 2'(c); cfg_ticks = 16'(t);
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 24) begin ecol[a] = c; etk[a] = t; end
  endtask

  task automatic wr_count(input int n);
    cfg_cnt_we = 1'b1; cfg_cnt = 5'(n);
    @(negedge clk);
    cfg_cnt_we = 1'b0;
  endtask

  task automatic pulse_start();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // walk n entries for at most limit cycles, checking every cycle
  task automatic play(input string req, input int n, input int limit, input bit idle_chk);
    int occ [3];
    int cyc;
    cyc = 0;
    for (int k = 0; k < 3; k++) occ[k] = 0;
    for (int e = 0; e < n; e++) begin
      int dur;
      dur = (etk[e] == 0) ? 1 : etk[e];
      for (int t = 0; t < dur; t++) begin
        logic [2:0] led;
        logic       lr;
        logic [1:0] lc;
        logic [4:0] li;
        if (cyc >= limit) return;
        led = (ecol[e] == 3) ? 3'b000 : 3'(1 << ecol[e]);
        lr  = (t == 0) && (ecol[e] != 3);
        lc  = lr ? 2'(ecol[e]) : 2'b00;
        li  = lr ? 5'(occ[ecol[e]]) : 5'd0;
        check(req, obs(), {20'd0, 1'b1, led, lr, lc, li});
        if (lr) occ[ecol[e]]++;
        @(negedge clk);
        cyc++;
      end
    end
    if (idle_chk) begin
      for (int k = 0; k < 2; k++) begin
        check("R6 trailing idle", obs(), 32'd0);
        @(negedge clk);
      end
    end
  endtask

  task automatic t_reset();
    check("R1 reset outputs", {27'd0, seq_active, led_en, load_req}, 32'd0);
    check("R1 reset overrun", {31'd0, overrun}, 32'd0);
  endtask

  task automatic t_interleaved();
    int cols [10] = '{2, 1, 0, 1, 0, 2, 1, 0, 1, 0};
    int tks  [10] = '{3, 2, 4, 1, 5, 2, 3, 2, 1, 4};
    for (int i = 0; i < 10; i++) wr_entry(i, cols[i], tks[i]);
    wr_count(10);
    pulse_start();
    play("R2 R3 R4 R5 R9 interleaved", 10, 1000, 1'b1);
    check("R6 no overrun after clean frame", {31'd0, overrun}, 32'd0);
  endtask

  task automatic t_dark_tail();
    wr_entry(0, 0, 3); wr_entry(1, 1, 3); wr_entry(2, 2, 2);
    wr_entry(3, 3, 2); wr_entry(4, 0, 3); wr_entry(5, 1, 3);
    wr_entry(6, 3, 4);
    wr_count(7);
    pulse_start();
    play("R3 R4 R9 dark segments", 7, 1000, 1'b1);
  endtask

  task automatic t_zero_ticks();
    wr_entry(0, 1, 0); wr_entry(1, 2, 0); wr_entry(2, 1, 2);
    wr_count(3);
    pulse_start();
    play("R3 zero tick count", 3, 1000, 1'b1);
  endtask

  task automatic t_empty();
    wr_count(0);
    pulse_start();
    for (int k = 0; k < 3; k++) begin
      check("R8 empty table stays idle", obs(), 32'd0);
      @(negedge clk);
    end
    check("R8 empty table no overrun", {31'd0, overrun}, 32'd0);
  endtask

  task automatic t_overrun();
    wr_entry(0, 0, 6); wr_entry(1, 1, 6);
    wr_count(2);
    pulse_start();
    play("R3 first frame", 2, 3, 1'b0);
    check("R7 flag clear before restart", {31'd0, overrun}, 32'd0);
    pulse_start();
    check("R7 overrun set", {31'd0, overrun}, 32'd1);
    play("R7 restart at entry 0", 2, 1000, 1'b1);
    check("R7 overrun sticky", {31'd0, overrun}, 32'd1);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 24; i++) wr_entry(i, i % 3, 1);
    wr_count(30);
    pulse_start();
    play("R8 count saturates at depth", 24, 1000, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_color = '0; cfg_ticks = '0;
    cfg_cnt_we = 1'b0; cfg_cnt = '0; frame_start = 1'b0;
    for (int i = 0; i < 24; i++) begin ecol[i] = 3; etk[i] = 0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_interleaved();
    t_dark_tail();
    t_zero_ticks();
    t_empty();
    t_overrun();
    t_saturate();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule